// File: doc/BRIEF.md
# Shared-Exponent Scaling Tracker for a Multi-Pass Transform

This block keeps one exponent for a whole sequence while a fixed-point transform engine works through it in passes. As each pass runs, the arithmetic datapath streams out beats of results. Each beat holds several results, and for every result it presents the top three bits of a word that is two bits wider than the storage format. From those bits the tracker works out how far the result grew past the stored range: none, one bit or two bits. It keeps the largest growth seen in the pass.

At each pass boundary that largest growth becomes the right shift the datapath applies to words as it reads them in the following pass, and the exponent goes up by the same amount. The array is therefore never rewritten for scaling alone. The amount of growth that can be charged to a pass is limited by its position in the transform. After the last pass, growth that no later read can absorb is added to the exponent and flagged so the host can shift the stored words itself. An inverse transform also removes log2N from the final exponent to account for its division by N.

The result stream is valid/ready. The tracker never applies back-pressure during a transform: ready equals busy, so ready is high for the whole run and low whenever the tracker is idle. A beat counts only in a cycle where valid and ready are both high. A producer that sees ready low must treat its beat as not taken. Start, pass end, mode, size, shift, exponent and status are plain level or pulse pins.

Top module: `bfp_scale_tracker`

## Requirements
- R1: A start pulse sets exponent and shift_amt to 0, busy to 1, and done and tail_flag to 0 at the next clock edge. The same edge latches inverse and log2n. If a beat or pass_end arrives in the cycle of start, it is discarded.
- R2: Growth of each result is read from its 3-bit field {b2,b1,b0}, where b0 is the sign position of the stored range. All three bits equal means growth 0. b2==b1 with b1!=b0 means growth 1. b2!=b1 means growth 2. Lane k occupies res_top[3k+2:3k].
- R3: res_ready equals busy. Only beats with res_valid and res_ready both high count. The pass growth is the largest over all lanes of all counted beats since the last boundary, including a beat counted in the same cycle as pass_end.
- R4: At a pass_end that is not the final one, shift_amt becomes the limited pass growth at the next edge, exponent rises by that amount, and the running growth restarts from 0.
- R5: The growth charged for passes 0 and 1 is at most 1. For later passes it is at most 2. shift_amt never holds 3.
- R6: The log2N-th pass_end ends the transform. Exponent rises by the limited final growth, tail_flag is set to 1 exactly when that growth is non-zero, shift_amt returns to 0, busy falls and done rises.
- R7: When the latched mode is inverse (inverse=1), the final step also subtracts the effective log2N from the exponent. The exponent is a two's-complement number.
- R8: The effective log2N is log2n limited to the range 2 to MAX_LOG2N, so a start with log2n=1 runs 2 passes and one with 15 runs 10.
- R9: While idle, pass_end and result beats have no effect. Exponent, done and tail_flag hold until the next start.
- R10: A start while busy abandons the current transform and begins a new one as in R1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a transform; latches log2n and inverse |
| log2n | input | 4 | Transform size as log2 of the point count |
| inverse | input | 1 | 1 selects the inverse transform |
| pass_end | input | 1 | Strobe marking the last cycle of a pass |
| res_valid | input | 1 | Result beat valid |
| res_ready | output | 1 | Result beat accepted (equals busy) |
| res_top | input | 12 | Top three bits of each of four results |
| shift_amt | output | 2 | Right shift to apply on reads in the next pass |
| exponent | output | 7 | Shared exponent, two's complement |
| busy | output | 1 | Transform in progress |
| done | output | 1 | Transform finished; exponent is final |
| tail_flag | output | 1 | Final pass grew; host must still shift the stored words |

## Verification
Every result of the tracker is registered once. Exponent, shift_amt, busy, done and tail_flag take their new values at the rising edge that samples start or pass_end, and the running growth absorbs a counted beat at the edge that samples it. The bench changes inputs only on falling edges. It holds each stimulus for exactly one cycle and reads the outputs at the following falling edge, half a cycle after the edge that must have updated them. In that way each check falls in the first cycle the new value is due, and before any later stimulus can disturb it.

// File: rtl/bfp_pkg.sv
package bfp_pkg;

  localparam int TOP_W = 3;

  typedef logic [1:0] growth_t;

  function automatic growth_t measure_growth(input logic [TOP_W-1:0] top);
    growth_t g;
    if (top[2] != top[1])      g = 2'd2;
    else if (top[1] != top[0]) g = 2'd1;
    else                       g = 2'd0;
    return g;
  endfunction

  function automatic growth_t growth_max(input growth_t a, input growth_t b);
    return (a > b) ? a : b;
  endfunction

  function automatic growth_t limit_growth(input growth_t g, input logic early);
    growth_t r;
    if (early) r = (g > 2'd1) ? 2'd1 : g;
    else       r = (g > 2'd2) ? 2'd2 : g;
    return r;
  endfunction

endpackage

// File: rtl/bfp_beat_growth.sv
module bfp_beat_growth #(
  parameter int LANES = 4
) (
  input  logic [LANES*bfp_pkg::TOP_W-1:0] res_top,
  output bfp_pkg::growth_t                 beat_max
);
  import bfp_pkg::*;

  growth_t lane_g [LANES];

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign lane_g[k] = measure_growth(res_top[k*TOP_W +: TOP_W]);
  end

  always_comb begin
    beat_max = 2'd0;
    for (int k = 0; k < LANES; k++) begin
      beat_max = growth_max(beat_max, lane_g[k]);
    end
  end
endmodule

// File: rtl/bfp_pass_seq.sv
module bfp_pass_seq #(
  parameter int MAX_LOG2N = 10,
  parameter int CNT_W     = $clog2(MAX_LOG2N + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] log2n,
  input  logic             inverse,
  input  logic             pass_end,
  output logic             busy,
  output logic             done,
  output logic             step,
  output logic             is_final,
  output logic             early,
  output logic             inv_q,
  output logic [CNT_W-1:0] nlog_q
);
  localparam logic [CNT_W-1:0] MIN_N = CNT_W'(2);
  localparam logic [CNT_W-1:0] MAX_N = CNT_W'(MAX_LOG2N);

  logic [CNT_W-1:0] pass_idx;
  logic [CNT_W-1:0] n_eff;

  always_comb begin
    if (log2n < MIN_N)      n_eff = MIN_N;
    else if (log2n > MAX_N) n_eff = MAX_N;
    else                    n_eff = log2n;
  end

  assign step     = busy && pass_end && !start;
  assign is_final = (pass_idx == nlog_q - CNT_W'(1));
  assign early    = (pass_idx < CNT_W'(2));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      done     <= 1'b0;
      pass_idx <= '0;
      nlog_q   <= MIN_N;
      inv_q    <= 1'b0;
    end else if (start) begin
      busy     <= 1'b1;
      done     <= 1'b0;
      pass_idx <= '0;
      nlog_q   <= n_eff;
      inv_q    <= inverse;
    end else if (step) begin
      if (is_final) begin
        busy <= 1'b0;
        done <= 1'b1;
      end else begin
        pass_idx <= pass_idx + CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/bfp_exp_unit.sv
module bfp_exp_unit #(
  parameter int CNT_W = 4,
  parameter int EXP_W = 7
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic                    accept,
  input  bfp_pkg::growth_t        beat_max,
  input  logic                    step,
  input  logic                    is_final,
  input  logic                    early,
  input  logic                    inv_q,
  input  logic [CNT_W-1:0]        nlog_q,
  output logic [1:0]              shift_amt,
  output logic signed [EXP_W-1:0] exponent,
  output logic                    tail_flag
);
  import bfp_pkg::*;

  growth_t                 run_max;
  growth_t                 acc;
  growth_t                 g_lim;
  logic signed [EXP_W-1:0] g_ext;
  logic signed [EXP_W-1:0] n_sub;

  always_comb begin
    acc   = accept ? growth_max(run_max, beat_max) : run_max;
    g_lim = limit_growth(acc, early);
    g_ext = $signed({{(EXP_W-2){1'b0}}, g_lim});
    n_sub = inv_q ? $signed({{(EXP_W-CNT_W){1'b0}}, nlog_q}) : '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || start) begin
      run_max   <= 2'd0;
      shift_amt <= 2'd0;
      exponent  <= '0;
      tail_flag <= 1'b0;
    end else if (step) begin
      run_max <= 2'd0;
      if (is_final) begin
        exponent  <= exponent + g_ext - n_sub;
        shift_amt <= 2'd0;
        tail_flag <= (g_lim != 2'd0);
      end else begin
        exponent  <= exponent + g_ext;
        shift_amt <= g_lim;
      end
    end else if (accept) begin
      run_max <= acc;
    end
  end
endmodule

// File: rtl/bfp_scale_tracker.sv
module bfp_scale_tracker #(
  parameter int LANES     = 4,
  parameter int MAX_LOG2N = 10,
  parameter int CNT_W     = $clog2(MAX_LOG2N + 1),
  parameter int EXP_W     = $clog2(2 * MAX_LOG2N) + 2,
  parameter int RES_W     = LANES * bfp_pkg::TOP_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic [CNT_W-1:0]        log2n,
  input  logic                    inverse,
  input  logic                    pass_end,
  input  logic                    res_valid,
  output logic                    res_ready,
  input  logic [RES_W-1:0]        res_top,
  output logic [1:0]              shift_amt,
  output logic signed [EXP_W-1:0] exponent,
  output logic                    busy,
  output logic                    done,
  output logic                    tail_flag
);
  import bfp_pkg::*;

  growth_t          beat_max;
  logic             step;
  logic             is_final;
  logic             early;
  logic             inv_q;
  logic [CNT_W-1:0] nlog_q;
  logic             accept;

  assign res_ready = busy;
  assign accept    = res_valid && res_ready && !start;

  bfp_beat_growth #(.LANES(LANES)) u_beat (
    .res_top  (res_top),
    .beat_max (beat_max)
  );

  bfp_pass_seq #(.MAX_LOG2N(MAX_LOG2N), .CNT_W(CNT_W)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .log2n    (log2n),
    .inverse  (inverse),
    .pass_end (pass_end),
    .busy     (busy),
    .done     (done),
    .step     (step),
    .is_final (is_final),
    .early    (early),
    .inv_q    (inv_q),
    .nlog_q   (nlog_q)
  );

  bfp_exp_unit #(.CNT_W(CNT_W), .EXP_W(EXP_W)) u_exp (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .accept    (accept),
    .beat_max  (beat_max),
    .step      (step),
    .is_final  (is_final),
    .early     (early),
    .inv_q     (inv_q),
    .nlog_q    (nlog_q),
    .shift_amt (shift_amt),
    .exponent  (exponent),
    .tail_flag (tail_flag)
  );
endmodule

// File: rtl/bfp_scale_tracker_chk.sv
module bfp_scale_tracker_chk #(
  parameter int MAX_LOG2N = 10,
  parameter int CNT_W     = 4,
  parameter int EXP_W     = 7
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    start,
  input logic [CNT_W-1:0]        log2n,
  input logic                    pass_end,
  input logic                    res_ready,
  input logic [1:0]              shift_amt,
  input logic signed [EXP_W-1:0] exponent,
  input logic                    busy,
  input logic                    done,
  input logic                    tail_flag
);
  logic [CNT_W-1:0] seen;
  logic [CNT_W-1:0] n_chk;
  logic             bound;
  logic             last;

  assign bound = busy && pass_end && !start;
  assign last  = (seen == n_chk - CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seen  <= '0;
      n_chk <= CNT_W'(2);
    end else if (start) begin
      seen  <= '0;
      n_chk <= (log2n < CNT_W'(2)) ? CNT_W'(2) :
               (log2n > CNT_W'(MAX_LOG2N)) ? CNT_W'(MAX_LOG2N) : log2n;
    end else if (bound) begin
      seen <= seen + CNT_W'(1);
    end
  end

  a_r1_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (exponent == '0 && shift_amt == 2'd0 && busy && !done && !tail_flag));

  a_r4_exp_follows_shift: assert property (@(posedge clk) disable iff (!rst_n)
    (bound && !last) |=> (int'(exponent) == int'($past(exponent)) + int'(shift_amt)));

  a_r5_early_limit: assert property (@(posedge clk) disable iff (!rst_n)
    (bound && seen < CNT_W'(2)) |=> (shift_amt <= 2'd1));

  a_r5_shift_range: assert property (@(posedge clk) disable iff (!rst_n)
    shift_amt != 2'd3);

  a_r6_final_ends: assert property (@(posedge clk) disable iff (!rst_n)
    (bound && last) |=> (done && !busy && shift_amt == 2'd0));

  a_r9_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> ($stable(exponent) && $stable(done) && $stable(tail_flag)));

  a_r3_idle_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> !res_ready);
endmodule

bind bfp_scale_tracker bfp_scale_tracker_chk #(
  .MAX_LOG2N(MAX_LOG2N), .CNT_W(CNT_W), .EXP_W(EXP_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .log2n     (log2n),
  .pass_end  (pass_end),
  .res_ready (res_ready),
  .shift_amt (shift_amt),
  .exponent  (exponent),
  .busy      (busy),
  .done      (done),
  .tail_flag (tail_flag)
);

// File: tb/bfp_scale_tracker_test.sv
module bfp_scale_tracker_test;
  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              start = 1'b0;
  logic [3:0]        log2n = 4'd0;
  logic              inverse = 1'b0;
  logic              pass_end = 1'b0;
  logic              res_valid = 1'b0;
  logic              res_ready;
  logic [11:0]       res_top = 12'h000;
  logic [1:0]        shift_amt;
  logic signed [6:0] exponent;
  logic              busy;
  logic              done;
  logic              tail_flag;

  int n_run  = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  bfp_scale_tracker uut (
    .clk(clk), .rst_n(rst_n), .start(start), .log2n(log2n), .inverse(inverse),
    .pass_end(pass_end), .res_valid(res_valid), .res_ready(res_ready),
    .res_top(res_top), .shift_amt(shift_amt), .exponent(exponent),
    .busy(busy), .done(done), .tail_flag(tail_flag)
  );

  // {res_top[11:0], shift[1:0], exponent[6:0], done, tail}, log2n=5 forward
  localparam logic [22:0] VEC [5] = '{
    {12'h007, 2'd0, 7'd0, 1'b0, 1'b0},
    {12'h080, 2'd1, 7'd1, 1'b0, 1'b0},
    {12'hA30, 2'd2, 7'd3, 1'b0, 1'b0},
    {12'h000, 2'd0, 7'd3, 1'b0, 1'b0},
    {12'h001, 2'd0, 7'd4, 1'b1, 1'b1}
  };

  task automatic check(input string tag, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic do_start(input logic [3:0] n, input logic inv);
    @(negedge clk);
    start = 1'b1; log2n = n; inverse = inv;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic cyc(input logic [11:0] top, input logic vld, input logic pe);
    @(negedge clk);
    res_top = top; res_valid = vld; pass_end = pe;
    @(negedge clk);
    res_valid = 1'b0; pass_end = 1'b0; res_top = 12'h000;
  endtask

  initial begin
    #1_000_000;
    n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic signed [6:0] held;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("reset exponent", int'(exponent), 0);
    check("reset shift", int'(shift_amt), 0);
    check("reset busy", int'(busy), 0);
    check("reset done", int'(done), 0);
    check("R3 reset ready", int'(res_ready), 0);

    // Table walk: R1, R2, R4, R5, R6
    do_start(4'd5, 1'b0);
    check("R1 busy after start", int'(busy), 1);
    check("R3 ready while busy", int'(res_ready), 1);
    for (int i = 0; i < 5; i++) begin
      cyc(VEC[i][22:11], 1'b1, 1'b1);
      check("R2 R4 R5 shift", int'(shift_amt), int'(VEC[i][10:9]));
      check("R4 R6 exponent", int'(exponent), int'($signed(VEC[i][8:2])));
      check("R6 done", int'(done), int'(VEC[i][1]));
      check("R6 tail", int'(tail_flag), int'(VEC[i][0]));
    end
    check("R6 busy low", int'(busy), 0);

    // R9: idle stimuli ignored
    held = exponent;
    cyc(12'h492, 1'b1, 1'b1);
    check("R9 idle exponent", int'(exponent), int'(held));
    check("R9 idle done", int'(done), 1);
    check("R9 idle tail", int'(tail_flag), 1);
    check("R3 idle ready", int'(res_ready), 0);

    // R7 inverse, log2n=3, final pass growth 2
    do_start(4'd3, 1'b1);
    check("R1 exponent cleared", int'(exponent), 0);
    check("R1 tail cleared", int'(tail_flag), 0);
    cyc(12'h000, 1'b1, 1'b1);
    cyc(12'h000, 1'b1, 1'b1);
    cyc(12'h010, 1'b1, 1'b1);
    check("R7 inverse exponent", int'(exponent), -1);
    check("R7 tail", int'(tail_flag), 1);
    check("R6 done", int'(done), 1);

    // R8: log2n=1 treated as 2, inverse
    do_start(4'd1, 1'b1);
    cyc(12'h001, 1'b1, 1'b1);
    check("R8 still busy after pass0", int'(busy), 1);
    check("R4 shift pass0", int'(shift_amt), 1);
    cyc(12'h000, 1'b1, 1'b1);
    check("R8 done after 2 passes", int'(done), 1);
    check("R8 R7 exponent", int'(exponent), -1);
    check("R6 tail clear", int'(tail_flag), 0);

    // R3: multi-beat, invalid beat ignored
    do_start(4'd4, 1'b0);
    cyc(12'h000, 1'b0, 1'b1);
    cyc(12'h000, 1'b0, 1'b1);
    cyc(12'h006, 1'b1, 1'b0);
    check("R3 no change mid pass", int'(shift_amt), 0);
    cyc(12'h002, 1'b0, 1'b0);
    cyc(12'h000, 1'b0, 1'b1);
    check("R3 shift from counted beat", int'(shift_amt), 1);
    check("R3 exponent", int'(exponent), 1);
    cyc(12'h000, 1'b0, 1'b1);
    check("R6 done pass4", int'(done), 1);
    check("R6 exponent final", int'(exponent), 1);

    // R10: restart while busy
    do_start(4'd4, 1'b0);
    cyc(12'h001, 1'b1, 1'b1);
    check("R10 exponent before restart", int'(exponent), 1);
    do_start(4'd2, 1'b0);
    check("R10 exponent cleared", int'(exponent), 0);
    check("R10 busy", int'(busy), 1);
    cyc(12'h000, 1'b1, 1'b1);
    cyc(12'h000, 1'b1, 1'b1);
    check("R10 done after new size", int'(done), 1);
    check("R10 exponent", int'(exponent), 0);

    // R8: log2n=15 clamped to 10
    do_start(4'd15, 1'b0);
    for (int p = 0; p < 9; p++) cyc(12'h000, 1'b1, 1'b1);
    check("R8 busy after 9 passes", int'(busy), 1);
    cyc(12'h000, 1'b1, 1'b1);
    check("R8 done after 10 passes", int'(done), 1);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule